// File: doc/BRIEF.md
# Multiplexed Parallel I/O Port Controller

This block controls one port of up to 32 I/O pins. For every pin it decides who drives the pad. The pad is driven either by a plain general-purpose output or by one of four internal peripheral functions, numbered 0 to 3. The block keeps the per-pin configuration: ownership, output enable, output level, pull-up, pull-down, open-drain, input filtering, Schmitt-trigger disable and a stored interrupt-off flag. It presents the synchronised, optionally filtered pin levels to software and to the peripherals.

Software reaches the block through a single-cycle register interface. A write strobe, a 5-bit register index and a write word go in. The read word is a combinational function of the index. Most attributes have a set register, a clear register and a status register. In a set or clear write, a 1 in a bit acts on that pin and a 0 leaves the pin untouched, so no read-modify-write is needed.

Top module: `pio_port_ctrl`

## Requirements
- R1: Reset state, as read from the status registers and the pads:
  - all pins are owned by the general-purpose function;
  - output enable, output data, open-drain, filter enable, filter select, pull-down, interrupt-off, both function selects, the divider and the Schmitt register are 0;
  - pull-up is 1 on every pin;
  - so padOe = 0 and padPullUp is all ones.
- R2: Each attribute has three registers, at (set, clear, status) indices:
  - ownership (0, 1, 2), output enable (3, 4, 5), filter enable (6, 7, 8);
  - interrupt-off (13, 14, 15), open-drain (16, 17, 18), pull-up (19, 20, 21), pull-down (28, 29, 30).
  - A 1 written to the set register sets that pin's bit, and a 1 written to the clear register clears it. Bits written as 0 keep their value. The status register returns the current bits.
- R3: A 1 written at index 9 raises a pin's output latch, and a 1 written at index 10 lowers it. Zero bits are unaffected. The latch reads back at index 11.
- R4: A pin that is not GPIO-owned takes its pad value and enable from peripheral function {sel2, sel1}. Index 22 holds the sel1 bits and index 23 the sel2 bits. (sel1, sel2) = (0,0) selects function 0, (1,0) selects 1, (0,1) selects 2 and (1,1) selects 3.
- R5: A GPIO-owned pin drives its output latch onto padOut and its output-enable bit onto padOe, whatever the peripherals drive.
- R6: On an open-drain pin, padOut is always 0. A logic 1 from the selected source turns padOe off instead of driving high, and a logic 0 drives low when enabled.
- R7: With filtering off, index 12 and pinLevel show pinIn delayed by exactly two clock edges, for every pin, whoever owns it.
- R8: With the filter on and select bit 0 (glitch mode), a pin level that lasts only one sampled cycle never reaches pinLevel. A lasting change appears on the fourth clock edge after pinIn changes.
- R9: With the filter on and select bit 1 (debounce mode), the level is sampled on ticks every (divider+1) clocks. The output follows only when two consecutive ticks agree, so a pulse shorter than one tick period is rejected. Index 25 sets select bits, index 24 clears them, index 26 reads them, and index 27 holds the divider.
- R10: padPullDown is active only where pull-down is on and pull-up is off. padPullUp follows the pull-up bits, so both pulls are never active on one pin.
- R11: Indices 22, 23, 27 and 31 are read/write. Index 31 is the Schmitt-disable register: a 1 disables the Schmitt trigger and appears on padSchmittOff. The divider reads back truncated to DIV_W bits.
- R12: A write to a status index (2, 5, 8, 11, 12, 15, 18, 21, 26, 30) changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | 5 | Register index |
| busWrData | input | NUM_PINS | Write word |
| busRdData | output | NUM_PINS | Read word for busAddr (combinational) |
| pinIn | input | NUM_PINS | Raw pad input levels |
| perAOut | input | NUM_PINS | Peripheral function 0 output values |
| perBOut | input | NUM_PINS | Peripheral function 1 output values |
| perCOut | input | NUM_PINS | Peripheral function 2 output values |
| perDOut | input | NUM_PINS | Peripheral function 3 output values |
| perAOe | input | NUM_PINS | Peripheral function 0 output enables |
| perBOe | input | NUM_PINS | Peripheral function 1 output enables |
| perCOe | input | NUM_PINS | Peripheral function 2 output enables |
| perDOe | input | NUM_PINS | Peripheral function 3 output enables |
| padOut | output | NUM_PINS | Pad output value |
| padOe | output | NUM_PINS | Pad output enable |
| padPullUp | output | NUM_PINS | Pull-up enable to pad |
| padPullDown | output | NUM_PINS | Pull-down enable to pad |
| padSchmittOff | output | NUM_PINS | Schmitt-trigger disable to pad |
| pinLevel | output | NUM_PINS | Synchronised, optionally filtered pin level |

## Verification
The bench builds the block with its defaults: NUM_PINS = 32, DIV_W = 16 and SYNC_STAGES = 2. The full port width lets masks hit both the top and bottom halves of a word. The 16-bit divider lets a write of all ones show truncation on read-back. Two synchroniser stages give a known two-edge latency that the glitch and debounce timings are measured against. Writing a divider of 3 shortens the debounce tick to four clocks, which puts both the pulse rejection and the acceptance of a held level within a few dozen cycles.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int unsigned REG_ADDR_W = 5;

  typedef enum logic [REG_ADDR_W-1:0] {
    RA_OWN_SET   = 5'd0,  RA_OWN_CLR  = 5'd1,  RA_OWN_STAT  = 5'd2,
    RA_OE_SET    = 5'd3,  RA_OE_CLR   = 5'd4,  RA_OE_STAT   = 5'd5,
    RA_FLT_SET   = 5'd6,  RA_FLT_CLR  = 5'd7,  RA_FLT_STAT  = 5'd8,
    RA_DAT_SET   = 5'd9,  RA_DAT_CLR  = 5'd10, RA_DAT_STAT  = 5'd11,
    RA_PIN_STAT  = 5'd12,
    RA_IRQ_SET   = 5'd13, RA_IRQ_CLR  = 5'd14, RA_IRQ_STAT  = 5'd15,
    RA_OD_SET    = 5'd16, RA_OD_CLR   = 5'd17, RA_OD_STAT   = 5'd18,
    RA_PU_SET    = 5'd19, RA_PU_CLR   = 5'd20, RA_PU_STAT   = 5'd21,
    RA_SEL1      = 5'd22, RA_SEL2     = 5'd23,
    RA_FSEL_CLR  = 5'd24, RA_FSEL_SET = 5'd25, RA_FSEL_STAT = 5'd26,
    RA_DIV       = 5'd27,
    RA_PD_SET    = 5'd28, RA_PD_CLR   = 5'd29, RA_PD_STAT   = 5'd30,
    RA_SCHMITT   = 5'd31
  } reg_id_e;

  // Attribute slots held in set/clear register pairs
  localparam int unsigned NUM_ATTR = 9;
  localparam int unsigned A_OWN  = 0;
  localparam int unsigned A_OE   = 1;
  localparam int unsigned A_FLT  = 2;
  localparam int unsigned A_DAT  = 3;
  localparam int unsigned A_IRQ  = 4;
  localparam int unsigned A_OD   = 5;
  localparam int unsigned A_PU   = 6;
  localparam int unsigned A_PD   = 7;
  localparam int unsigned A_FSEL = 8;
  // Slots that come out of reset as all ones
  localparam logic [NUM_ATTR-1:0] ATTR_RST_ONES = NUM_ATTR'((1 << A_OWN) | (1 << A_PU));

  typedef struct packed {
    logic [NUM_ATTR-1:0] attrSet;
    logic [NUM_ATTR-1:0] attrClr;
    logic                sel1Wr;
    logic                sel2Wr;
    logic                divWr;
    logic                schWr;
  } strobe_t;

endpackage

// File: rtl/pio_attr_reg.sv
module pio_attr_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         setStb,
  input  logic         clrStb,
  input  logic [W-1:0] mask,
  output logic [W-1:0] state
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= RST_VAL;
    end else if (setStb) begin
      state <= state | mask;
    end else if (clrStb) begin
      state <= state & ~mask;
    end
  end

endmodule

// File: rtl/pio_infilter.sv
module pio_infilter #(
  parameter int unsigned W           = 32,
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [W-1:0]     pinIn,
  input  logic [DIV_W-1:0] divVal,
  input  logic [W-1:0]     fltEn,
  input  logic [W-1:0]     fltDeb,
  output logic [W-1:0]     level
);

  logic [SYNC_STAGES-1:0][W-1:0] syncQ;
  logic [W-1:0] syncOut;
  logic [W-1:0] gPrev, gOut;
  logic [W-1:0] dHist, dOut;
  logic [DIV_W-1:0] divCnt;
  logic tick;

  // Synchroniser chain, length set by SYNC_STAGES
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[0] <= '0;
          else       syncQ[0] <= pinIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncQ[s] <= '0;
          else       syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  assign syncOut = syncQ[SYNC_STAGES-1];

  // Glitch filter: follow only when two consecutive samples agree
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gPrev <= '0;
      gOut  <= '0;
    end else begin
      gPrev <= syncOut;
      gOut  <= (syncOut & gPrev) | (gOut & (syncOut | gPrev));
    end
  end

  // Slow sample tick for the debounce filter
  assign tick = (divCnt >= divVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     divCnt <= '0;
    else if (tick) divCnt <= '0;
    else           divCnt <= divCnt + 1'b1;
  end

  // Debounce filter: follow only when two consecutive ticks agree
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dHist <= '0;
      dOut  <= '0;
    end else if (tick) begin
      dHist <= syncOut;
      dOut  <= (syncOut & dHist) | (dOut & (syncOut | dHist));
    end
  end

  assign level = (~fltEn & syncOut)
               | (fltEn & ~fltDeb & gOut)
               | (fltEn &  fltDeb & dOut);

endmodule

// File: rtl/pio_ctrl.sv
module pio_ctrl
  import pio_pkg::*;
(
  input  logic                  busWr,
  input  logic [REG_ADDR_W-1:0] busAddr,
  output strobe_t               stb,
  output reg_id_e               rdSel
);

  assign rdSel = reg_id_e'(busAddr);

  always_comb begin
    stb = '0;
    if (busWr) begin
      case (rdSel)
        RA_OWN_SET:  stb.attrSet[A_OWN]  = 1'b1;
        RA_OWN_CLR:  stb.attrClr[A_OWN]  = 1'b1;
        RA_OE_SET:   stb.attrSet[A_OE]   = 1'b1;
        RA_OE_CLR:   stb.attrClr[A_OE]   = 1'b1;
        RA_FLT_SET:  stb.attrSet[A_FLT]  = 1'b1;
        RA_FLT_CLR:  stb.attrClr[A_FLT]  = 1'b1;
        RA_DAT_SET:  stb.attrSet[A_DAT]  = 1'b1;
        RA_DAT_CLR:  stb.attrClr[A_DAT]  = 1'b1;
        RA_IRQ_SET:  stb.attrSet[A_IRQ]  = 1'b1;
        RA_IRQ_CLR:  stb.attrClr[A_IRQ]  = 1'b1;
        RA_OD_SET:   stb.attrSet[A_OD]   = 1'b1;
        RA_OD_CLR:   stb.attrClr[A_OD]   = 1'b1;
        RA_PU_SET:   stb.attrSet[A_PU]   = 1'b1;
        RA_PU_CLR:   stb.attrClr[A_PU]   = 1'b1;
        RA_PD_SET:   stb.attrSet[A_PD]   = 1'b1;
        RA_PD_CLR:   stb.attrClr[A_PD]   = 1'b1;
        RA_FSEL_SET: stb.attrSet[A_FSEL] = 1'b1;
        RA_FSEL_CLR: stb.attrClr[A_FSEL] = 1'b1;
        RA_SEL1:     stb.sel1Wr          = 1'b1;
        RA_SEL2:     stb.sel2Wr          = 1'b1;
        RA_DIV:      stb.divWr           = 1'b1;
        RA_SCHMITT:  stb.schWr           = 1'b1;
        default:     ;
      endcase
    end
  end

endmodule

// File: rtl/pio_datapath.sv
module pio_datapath
  import pio_pkg::*;
#(
  parameter int unsigned W           = 32,
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  reg_id_e           rdSel,
  input  logic [W-1:0]      wrData,
  output logic [W-1:0]      rdData,
  input  logic [W-1:0]      pinIn,
  input  logic [3:0][W-1:0] perOut,
  input  logic [3:0][W-1:0] perOe,
  output logic [W-1:0]      padOut,
  output logic [W-1:0]      padOe,
  output logic [W-1:0]      padPullUp,
  output logic [W-1:0]      padPullDown,
  output logic [W-1:0]      padSchmittOff,
  output logic [W-1:0]      pinLevel,
  output logic [W-1:0]      ownState,
  output logic [W-1:0]      odState,
  output logic [W-1:0]      fltState
);

  logic [NUM_ATTR-1:0][W-1:0] attrQ;
  logic [W-1:0]     sel1Q, sel2Q, schQ;
  logic [DIV_W-1:0] divQ;

  // Set/clear attribute registers
  generate
    for (genvar k = 0; k < NUM_ATTR; k++) begin : g_attr
      pio_attr_reg #(
        .W      (W),
        .RST_VAL({W{ATTR_RST_ONES[k]}})
      ) attr_i (
        .clk   (clk),
        .rstN  (rstN),
        .setStb(stb.attrSet[k]),
        .clrStb(stb.attrClr[k]),
        .mask  (wrData),
        .state (attrQ[k])
      );
    end
  endgenerate

  // Plain read/write registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sel1Q <= '0;
      sel2Q <= '0;
      schQ  <= '0;
      divQ  <= '0;
    end else begin
      if (stb.sel1Wr) sel1Q <= wrData;
      if (stb.sel2Wr) sel2Q <= wrData;
      if (stb.schWr)  schQ  <= wrData;
      if (stb.divWr)  divQ  <= wrData[DIV_W-1:0];
    end
  end

  // Input path
  pio_infilter #(
    .W          (W),
    .DIV_W      (DIV_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) filt_i (
    .clk   (clk),
    .rstN  (rstN),
    .pinIn (pinIn),
    .divVal(divQ),
    .fltEn (attrQ[A_FLT]),
    .fltDeb(attrQ[A_FSEL]),
    .level (pinLevel)
  );

  // Per-pin source selection and open-drain shaping
  generate
    for (genvar i = 0; i < W; i++) begin : g_pin
      logic [1:0] fnCode;
      logic srcOut, srcOe;
      assign fnCode = {sel2Q[i], sel1Q[i]};
      assign srcOut = attrQ[A_OWN][i] ? attrQ[A_DAT][i] : perOut[fnCode][i];
      assign srcOe  = attrQ[A_OWN][i] ? attrQ[A_OE][i]  : perOe[fnCode][i];
      assign padOut[i] = srcOut & ~attrQ[A_OD][i];
      assign padOe[i]  = srcOe & ~(attrQ[A_OD][i] & srcOut);
    end
  endgenerate

  assign padPullUp     = attrQ[A_PU];
  assign padPullDown   = attrQ[A_PD] & ~attrQ[A_PU];
  assign padSchmittOff = schQ;
  assign ownState      = attrQ[A_OWN];
  assign odState       = attrQ[A_OD];
  assign fltState      = attrQ[A_FLT];

  always_comb begin
    case (rdSel)
      RA_OWN_STAT:  rdData = attrQ[A_OWN];
      RA_OE_STAT:   rdData = attrQ[A_OE];
      RA_FLT_STAT:  rdData = attrQ[A_FLT];
      RA_DAT_STAT:  rdData = attrQ[A_DAT];
      RA_PIN_STAT:  rdData = pinLevel;
      RA_IRQ_STAT:  rdData = attrQ[A_IRQ];
      RA_OD_STAT:   rdData = attrQ[A_OD];
      RA_PU_STAT:   rdData = attrQ[A_PU];
      RA_PD_STAT:   rdData = attrQ[A_PD];
      RA_FSEL_STAT: rdData = attrQ[A_FSEL];
      RA_SEL1:      rdData = sel1Q;
      RA_SEL2:      rdData = sel2Q;
      RA_SCHMITT:   rdData = schQ;
      RA_DIV:       rdData = W'(divQ);
      default:      rdData = '0;
    endcase
  end

endmodule

// File: rtl/pio_port_ctrl.sv
module pio_port_ctrl
  import pio_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 32,
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  busWr,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [NUM_PINS-1:0]   busWrData,
  output logic [NUM_PINS-1:0]   busRdData,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic [NUM_PINS-1:0]   perAOut,
  input  logic [NUM_PINS-1:0]   perBOut,
  input  logic [NUM_PINS-1:0]   perCOut,
  input  logic [NUM_PINS-1:0]   perDOut,
  input  logic [NUM_PINS-1:0]   perAOe,
  input  logic [NUM_PINS-1:0]   perBOe,
  input  logic [NUM_PINS-1:0]   perCOe,
  input  logic [NUM_PINS-1:0]   perDOe,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [NUM_PINS-1:0]   padPullUp,
  output logic [NUM_PINS-1:0]   padPullDown,
  output logic [NUM_PINS-1:0]   padSchmittOff,
  output logic [NUM_PINS-1:0]   pinLevel
);

  strobe_t stb;
  reg_id_e rdSel;
  logic [3:0][NUM_PINS-1:0] perOutV, perOeV;
  logic [NUM_PINS-1:0] ownState, odState, fltState;

  assign perOutV = {perDOut, perCOut, perBOut, perAOut};
  assign perOeV  = {perDOe, perCOe, perBOe, perAOe};

  pio_ctrl ctrl_i (
    .busWr  (busWr),
    .busAddr(busAddr),
    .stb    (stb),
    .rdSel  (rdSel)
  );

  pio_datapath #(
    .W          (NUM_PINS),
    .DIV_W      (DIV_W),
    .SYNC_STAGES(SYNC_STAGES)
  ) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .stb          (stb),
    .rdSel        (rdSel),
    .wrData       (busWrData),
    .rdData       (busRdData),
    .pinIn        (pinIn),
    .perOut       (perOutV),
    .perOe        (perOeV),
    .padOut       (padOut),
    .padOe        (padOe),
    .padPullUp    (padPullUp),
    .padPullDown  (padPullDown),
    .padSchmittOff(padSchmittOff),
    .pinLevel     (pinLevel),
    .ownState     (ownState),
    .odState      (odState),
    .fltState     (fltState)
  );

endmodule

// File: rtl/pio_port_chk.sv
module pio_port_chk
  import pio_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  busWr,
  input logic [REG_ADDR_W-1:0] busAddr,
  input logic [W-1:0]          busWrData,
  input logic [W-1:0]          pinIn,
  input logic [W-1:0]          padOut,
  input logic [W-1:0]          padOe,
  input logic [W-1:0]          padPullUp,
  input logic [W-1:0]          padPullDown,
  input logic [W-1:0]          pinLevel,
  input logic [W-1:0]          ownState,
  input logic [W-1:0]          odState,
  input logic [W-1:0]          fltState
);

  logic [1:0] sinceRst;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 sinceRst <= '0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R10
  pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padPullDown) == '0);

  // R6
  open_drain_low_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & odState) == '0);

  // R2
  pullup_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == RA_PU_SET) |=>
      ((padPullUp & $past(busWrData)) == $past(busWrData)));

  // R5
  oe_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == RA_OE_CLR) |=>
      ((padOe & $past(busWrData) & ownState) == '0));

  // R7
  sync_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (((pinLevel ^ $past(pinIn, 2)) & ~fltState) == '0));

endmodule

bind pio_port_ctrl pio_port_chk #(.W(NUM_PINS)) chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .busWr      (busWr),
  .busAddr    (busAddr),
  .busWrData  (busWrData),
  .pinIn      (pinIn),
  .padOut     (padOut),
  .padOe      (padOe),
  .padPullUp  (padPullUp),
  .padPullDown(padPullDown),
  .pinLevel   (pinLevel),
  .ownState   (ownState),
  .odState    (odState),
  .fltState   (fltState)
);

// File: tb/pio_port_ctrl_tb.sv
module pio_port_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0;
  logic [4:0] busAddr = '0;
  logic [W-1:0] busWrData = '0;
  logic [W-1:0] busRdData;
  logic [W-1:0] pinIn = '0;
  logic [W-1:0] perAOut = '0, perBOut = '0, perCOut = '0, perDOut = '0;
  logic [W-1:0] perAOe = '0, perBOe = '0, perCOe = '0, perDOe = '0;
  logic [W-1:0] padOut, padOe, padPullUp, padPullDown, padSchmittOff, pinLevel;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  pio_port_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .pinIn(pinIn),
    .perAOut(perAOut), .perBOut(perBOut), .perCOut(perCOut), .perDOut(perDOut),
    .perAOe(perAOe), .perBOe(perBOe), .perCOe(perCOe), .perDOe(perDOe),
    .padOut(padOut), .padOe(padOe), .padPullUp(padPullUp),
    .padPullDown(padPullDown), .padSchmittOff(padSchmittOff), .pinLevel(pinLevel)
  );

  typedef struct packed {
    logic [4:0]   wrAddr;
    logic [W-1:0] wrVal;
    logic [4:0]   rdAddr;
    logic [W-1:0] expVal;
  } vec_t;

  localparam int NVEC = 19;
  localparam vec_t VECS [NVEC] = '{
    '{5'd3,  32'h0000_00F0, 5'd5,  32'h0000_00F0},  // R2 set
    '{5'd3,  32'h0000_0F00, 5'd5,  32'h0000_0FF0},  // R2 zero bits kept
    '{5'd4,  32'h0000_0030, 5'd5,  32'h0000_0FC0},  // R2 clear
    '{5'd20, 32'hFFFF_0000, 5'd21, 32'h0000_FFFF},  // R2 pull-up clear
    '{5'd19, 32'h0001_0000, 5'd21, 32'h0001_FFFF},  // R2 pull-up set
    '{5'd9,  32'h0000_00A5, 5'd11, 32'h0000_00A5},  // R3 data set
    '{5'd10, 32'h0000_0005, 5'd11, 32'h0000_00A0},  // R3 data clear
    '{5'd22, 32'h1234_5678, 5'd22, 32'h1234_5678},  // R11 sel1
    '{5'd23, 32'h0F0F_0F0F, 5'd23, 32'h0F0F_0F0F},  // R11 sel2
    '{5'd31, 32'h8000_0001, 5'd31, 32'h8000_0001},  // R11 schmitt
    '{5'd27, 32'hFFFF_FFFF, 5'd27, 32'h0000_FFFF},  // R11 divider width
    '{5'd2,  32'h0000_0000, 5'd2,  32'hFFFF_FFFF},  // R12 status write ignored
    '{5'd13, 32'h0000_0003, 5'd15, 32'h0000_0003},  // R2 irq-off set
    '{5'd14, 32'h0000_0001, 5'd15, 32'h0000_0002},  // R2 irq-off clear
    '{5'd28, 32'h0000_FF00, 5'd30, 32'h0000_FF00},  // R2 pull-down set
    '{5'd6,  32'h0000_0001, 5'd8,  32'h0000_0001},  // R2 filter set
    '{5'd7,  32'h0000_0001, 5'd8,  32'h0000_0000},  // R2 filter clear
    '{5'd25, 32'h0000_0006, 5'd26, 32'h0000_0006},  // R9 select set
    '{5'd24, 32'h0000_0002, 5'd26, 32'h0000_0004}   // R9 select clear
  };

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [W-1:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWr = 1'b0; busWrData = '0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [W-1:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles(3);
    rstN = 1'b1;
    cycles(1);

    // R1 reset state
    busRead(5'd2,  rd); check("R1 own", rd, '1);
    busRead(5'd5,  rd); check("R1 oe", rd, '0);
    busRead(5'd21, rd); check("R1 pull-up", rd, '1);
    busRead(5'd30, rd); check("R1 pull-down", rd, '0);
    busRead(5'd8,  rd); check("R1 filter", rd, '0);
    check("R1 padOe", padOe, '0);
    check("R1 padPullUp", padPullUp, '1);

    // Register table
    for (int v = 0; v < NVEC; v++) begin
      busWrite(VECS[v].wrAddr, VECS[v].wrVal);
      busRead(VECS[v].rdAddr, rd);
      check($sformatf("vector %0d (R2/R3/R9/R11/R12)", v), rd, VECS[v].expVal);
    end

    // R10 pull priority
    check("R10 no pull-down under pull-up", padPullDown, 32'h0);
    busWrite(5'd20, 32'h0000_F000);
    check("R10 pull-down", padPullDown, 32'h0000_F000);
    check("R10 pull-up", padPullUp, 32'h0001_0FFF);

    // R5 GPIO path
    perAOut = '1; perAOe = '1;
    #1;
    check("R5 padOut", padOut, 32'h0000_00A0);
    check("R5 padOe", padOe, 32'h0000_0FC0);
    perAOut = '0; perAOe = '0;

    // R6 open drain on pins 6,7
    busWrite(5'd16, 32'h0000_00C0);
    check("R6 padOut", padOut, 32'h0000_0020);
    check("R6 padOe", padOe, 32'h0000_0F40);
    busWrite(5'd17, 32'h0000_00C0);

    // R4 peripheral selection on pins 0..3
    busWrite(5'd22, 32'h0000_000A);
    busWrite(5'd23, 32'h0000_000C);
    busWrite(5'd1,  32'h0000_000F);
    perAOut = 32'h1; #1;
    check("R4 function 0", padOut & 32'hF, 32'h1);
    perAOut = '0; perDOut = 32'h8; #1;
    check("R4 function 3", padOut & 32'hF, 32'h8);
    perDOut = '0; perBOut = 32'h1; #1;
    check("R4 unselected ignored", padOut & 32'hF, 32'h0);
    perBOut = 32'h2; perCOe = 32'h4; #1;
    check("R4 function 1 out", padOut & 32'hF, 32'h2);
    check("R4 function 2 oe", padOe & 32'hF, 32'h4);
    perBOut = '0; perCOe = '0;
    busWrite(5'd0, 32'h0000_000F);
    check("R5 reclaimed", padOut & 32'hF, 32'h0);

    // R11 schmitt pad
    check("R11 padSchmittOff", padSchmittOff, 32'h8000_0001);

    // R7 two-edge synchroniser latency
    pinIn = 32'h0000_0100;
    @(negedge clk);
    busRead(5'd12, rd); check("R7 after one edge", rd & 32'h100, 32'h0);
    @(negedge clk);
    busRead(5'd12, rd); check("R7 after two edges", rd & 32'h100, 32'h100);

    // R8 glitch filter on pin 8
    busWrite(5'd6, 32'h0000_0100);
    cycles(4);
    check("R8 filtered high", pinLevel & 32'h100, 32'h100);
    pinIn = 32'h0;
    @(negedge clk);
    pinIn = 32'h0000_0100;
    begin
      int bad = 0;
      for (int i = 0; i < 8; i++) begin
        @(negedge clk);
        if ((pinLevel & 32'h100) != 32'h100) bad++;
      end
      check("R8 one-cycle pulse rejected", 32'(bad), 32'h0);
    end
    pinIn = 32'h0;
    cycles(3);
    check("R8 not yet after three edges", pinLevel & 32'h100, 32'h100);
    cycles(1);
    check("R8 follows on fourth edge", pinLevel & 32'h100, 32'h0);

    // R9 debounce filter on pin 8, tick every 4 clocks
    busWrite(5'd27, 32'h3);
    busWrite(5'd25, 32'h0000_0100);
    cycles(20);
    check("R9 settled low", pinLevel & 32'h100, 32'h0);
    pinIn = 32'h0000_0100;
    cycles(3);
    pinIn = 32'h0;
    begin
      int bad = 0;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk);
        if ((pinLevel & 32'h100) != 32'h0) bad++;
      end
      check("R9 short pulse rejected", 32'(bad), 32'h0);
    end
    pinIn = 32'h0000_0100;
    cycles(4);
    check("R9 not yet", pinLevel & 32'h100, 32'h0);
    cycles(16);
    check("R9 held level accepted", pinLevel & 32'h100, 32'h100);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule